// File: doc/BRIEF.md
# Audio Sample DMA Byte Sequencer

This block sits between an 8-bit host transfer bus and the 16-bit left/right sample words of an audio path. It has two channels that run at the same time. The playback channel collects bytes from the bus into a stereo sample frame and hands the frame to the output path on each sample-rate strobe. The capture channel takes a stereo sample from the input path on each strobe and hands it out one byte at a time.

Each channel either raises a DMA request and steps on the acknowledges it receives, or, in programmed-I/O mode, steps on a host data-register strobe while its request stays low. The byte order comes from the channel's data format. The left channel always goes before the right. In 16-bit formats the two bytes of each channel come low byte first (little endian) or high byte first (big endian). Two status flags per channel say whether the byte needed next is an upper or lower byte and whether it belongs to the left or right channel. A sticky flag records a playback frame that was still incomplete when the strobe arrived.

Top module: `dma_byte_seq`

## Requirements
- R1: While reset is held and just after it is released, both requests and `drq_any` are low, `underrun` is 0, and `play_l`/`play_r` are 0.
- R2: A request rises only in the cycle after a sample-rate strobe, and only while its channel is enabled and in DMA mode. It stays high until the acknowledge of the last byte of the frame, then stays low until the next strobe.
- R3: Format code `00` or `11` is 8-bit, `01` is 16-bit little endian and `10` is 16-bit big endian. A frame holds 1 byte (8-bit mono), 2 bytes (8-bit stereo or 16-bit mono) or 4 bytes (16-bit stereo). Left bytes come before right bytes. The `*_upper` flag is 1 for every 8-bit byte. In 16-bit formats it is 0 for the first byte of each channel in little endian and 1 for that byte in big endian. The `*_right` flag is 1 only for the second half of a stereo frame.
- R4: On a strobe that finds a complete playback frame, `play_l`/`play_r` load the assembled words. An 8-bit byte fills bits 15:8 and bits 7:0 are zero. A 16-bit upper byte fills bits 15:8. In mono, `play_r` equals `play_l`. The outputs change at no other time.
- R5: A capture strobe latches `cap_l` and `cap_r`, with the right word forced to zero in mono, and restarts the frame. `cap_rdata` shows the latched byte named by the slot flags. It shows bits 15:8 when `cap_upper` is 1 and bits 7:0 when it is 0. In mono `cap_right` is always 0.
- R6: A strobe that arrives while an enabled playback frame is incomplete sets `underrun`. The flag stays set until a cycle with `underrun_clr` high and no new underrun. If set and clear fall in the same cycle, set wins. The playback outputs keep their previous values.
- R7: With a channel's PIO-select input high, its request stays low. Its PIO strobe (`play_pio_wr`/`cap_pio_rd`) steps the byte sequence in place of the acknowledge, and the acknowledge is ignored.
- R8: An acknowledge that arrives while the channel's request is low does not change any assembled or output data.
- R9: The two channels run independently, and `drq_any` is high whenever either request is high.
- R10: Clearing a channel's enable takes it back to idle. Its request goes low, and the next frame starts again from the first byte slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_tick | input | 1 | Sample-rate strobe, one cycle per sample period |
| underrun_clr | input | 1 | Host write that clears the underrun flag |
| play_en | input | 1 | Playback enable |
| play_pio | input | 1 | Playback PIO select (1 = PIO, 0 = DMA) |
| play_fmt | input | 2 | Playback format code |
| play_stereo | input | 1 | Playback stereo (1) or mono (0) |
| play_dak | input | 1 | Playback DMA acknowledge, one byte per high cycle |
| play_pio_wr | input | 1 | Playback data-register write strobe |
| play_wdata | input | BYTE_W | Playback byte from the bus |
| play_drq | output | 1 | Playback DMA request |
| play_upper | output | 1 | Next playback byte is an upper byte |
| play_right | output | 1 | Next playback byte is for the right channel |
| play_l | output | 2*BYTE_W | Left sample word to the output path |
| play_r | output | 2*BYTE_W | Right sample word to the output path |
| cap_en | input | 1 | Capture enable |
| cap_pio | input | 1 | Capture PIO select (1 = PIO, 0 = DMA) |
| cap_fmt | input | 2 | Capture format code |
| cap_stereo | input | 1 | Capture stereo (1) or mono (0) |
| cap_dak | input | 1 | Capture DMA acknowledge, one byte per high cycle |
| cap_pio_rd | input | 1 | Capture data-register read strobe |
| cap_l | input | 2*BYTE_W | Left sample word from the input path |
| cap_r | input | 2*BYTE_W | Right sample word from the input path |
| cap_drq | output | 1 | Capture DMA request |
| cap_upper | output | 1 | Next capture byte is an upper byte |
| cap_right | output | 1 | Next capture byte is from the right channel |
| cap_rdata | output | BYTE_W | Capture byte to the bus |
| drq_any | output | 1 | Level of either request |
| underrun | output | 1 | Sticky playback underrun flag |

## Verification
The bench sweeps all four format codes in both mono and stereo on each channel. At every byte it checks the slot flags and the assembled or presented data. A design with the wrong endian or left/right order shows wrong flags and swapped bytes, and one that mishandles the reserved code gives it a frame of the wrong length. After the last byte, the bench sends a stray acknowledge and checks that the request falls. A sequencer that kept requesting would be caught there, and one that accepted the stray byte would corrupt the output word. The bench also covers these cases:
- An underrun, including set and clear in the same cycle. A non-sticky flag or a clear-first priority loses the event, and a design that updates the output on an incomplete frame puts out a half-written word.
- A disable in the middle of a frame. A design that forgets the byte position starts the next frame on the wrong slot.
- Capture input that changes after the strobe. A design without a holding register reads out bytes that were never latched.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  typedef enum logic [1:0] {
    FMT_U8   = 2'b00,
    FMT_LE16 = 2'b01,
    FMT_BE16 = 2'b10,
    FMT_RSV  = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    CH_IDLE = 2'b00,
    CH_FILL = 2'b01,
    CH_FULL = 2'b10
  } ch_state_e;

  function automatic logic fmt_is16(input logic [1:0] f);
    return (f == FMT_LE16) || (f == FMT_BE16);
  endfunction

  function automatic logic fmt_be(input logic [1:0] f);
    return f == FMT_BE16;
  endfunction

  // bytes in one sample frame: 1, 2 or 4
  function automatic logic [2:0] frame_len(input logic [1:0] f, input logic st);
    logic [2:0] n;
    n = fmt_is16(f) ? 3'd2 : 3'd1;
    if (st) n = n << 1;
    return n;
  endfunction

endpackage

// File: rtl/dseq_slot_map.sv
module dseq_slot_map
  import dseq_pkg::*;
(
  input  logic [1:0] fmt,
  input  logic       stereo,
  input  logic [1:0] idx,
  output logic       upper,
  output logic       right,
  output logic       last
);
  logic       wide;
  logic [2:0] len;

  assign wide  = fmt_is16(fmt);
  assign len   = frame_len(fmt, stereo);
  assign right = stereo && (wide ? idx[1] : idx[0]);
  assign upper = !wide || (idx[0] ^ fmt_be(fmt));
  assign last  = ({1'b0, idx} == (len - 3'd1));
endmodule

// File: rtl/dseq_play_chan.sv
module dseq_play_chan
  import dseq_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              pio,
  input  logic [1:0]        fmt,
  input  logic              stereo,
  input  logic              dak,
  input  logic              pio_stb,
  input  logic [BYTE_W-1:0] wdata,
  output logic              drq,
  output logic              upper,
  output logic              right,
  output logic [WORD_W-1:0] out_l,
  output logic [WORD_W-1:0] out_r,
  output logic              last_evt,
  output logic              ur_evt
);
  ch_state_e         st_q;
  logic [1:0]        idx_q;
  logic [WORD_W-1:0] asm_l_q, asm_r_q;
  logic [WORD_W-1:0] out_l_q, out_r_q;
  logic              slot_up, slot_rt, slot_last;
  logic              step;

  dseq_slot_map u_map (
    .fmt    (fmt),
    .stereo (stereo),
    .idx    (idx_q),
    .upper  (slot_up),
    .right  (slot_rt),
    .last   (slot_last)
  );

  // place one bus byte into a sample word
  function automatic logic [WORD_W-1:0] put_byte(
    input logic [WORD_W-1:0] w,
    input logic [BYTE_W-1:0] b,
    input logic              up,
    input logic              wide
  );
    logic [WORD_W-1:0] r;
    r = w;
    if (!wide)   r = {b, {BYTE_W{1'b0}}};
    else if (up) r[WORD_W-1:BYTE_W] = b;
    else         r[BYTE_W-1:0] = b;
    return r;
  endfunction

  assign drq      = en && !pio && (st_q == CH_FILL);
  assign step     = en && (st_q == CH_FILL) && (pio ? pio_stb : dak);
  assign last_evt = step && slot_last;
  assign ur_evt   = en && tick && (st_q == CH_FILL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= CH_IDLE;
      idx_q   <= '0;
      asm_l_q <= '0;
      asm_r_q <= '0;
      out_l_q <= '0;
      out_r_q <= '0;
    end else if (!en) begin
      st_q  <= CH_IDLE;
      idx_q <= '0;
    end else begin
      if (step) begin
        if (slot_rt) asm_r_q <= put_byte(asm_r_q, wdata, slot_up, fmt_is16(fmt));
        else         asm_l_q <= put_byte(asm_l_q, wdata, slot_up, fmt_is16(fmt));
        if (slot_last) begin
          st_q  <= CH_FULL;
          idx_q <= '0;
        end else begin
          idx_q <= idx_q + 2'd1;
        end
      end
      if (tick) begin
        case (st_q)
          CH_IDLE: begin
            st_q  <= CH_FILL;
            idx_q <= '0;
          end
          CH_FULL: begin
            out_l_q <= asm_l_q;
            out_r_q <= stereo ? asm_r_q : asm_l_q;
            st_q    <= CH_FILL;
            idx_q   <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  assign upper = slot_up;
  assign right = slot_rt;
  assign out_l = out_l_q;
  assign out_r = out_r_q;
endmodule

// File: rtl/dseq_cap_chan.sv
module dseq_cap_chan
  import dseq_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              pio,
  input  logic [1:0]        fmt,
  input  logic              stereo,
  input  logic              dak,
  input  logic              pio_stb,
  input  logic [WORD_W-1:0] in_l,
  input  logic [WORD_W-1:0] in_r,
  output logic              drq,
  output logic              upper,
  output logic              right,
  output logic [BYTE_W-1:0] rdata,
  output logic              last_evt
);
  ch_state_e         st_q;
  logic [1:0]        idx_q;
  logic [WORD_W-1:0] hold_l_q, hold_r_q;
  logic              slot_up, slot_rt, slot_last;
  logic              step;

  dseq_slot_map u_map (
    .fmt    (fmt),
    .stereo (stereo),
    .idx    (idx_q),
    .upper  (slot_up),
    .right  (slot_rt),
    .last   (slot_last)
  );

  function automatic logic [BYTE_W-1:0] pick_byte(
    input logic [WORD_W-1:0] w,
    input logic              up
  );
    return up ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction

  assign drq      = en && !pio && (st_q == CH_FILL);
  assign step     = en && (st_q == CH_FILL) && (pio ? pio_stb : dak);
  assign last_evt = step && slot_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= CH_IDLE;
      idx_q    <= '0;
      hold_l_q <= '0;
      hold_r_q <= '0;
    end else if (!en) begin
      st_q  <= CH_IDLE;
      idx_q <= '0;
    end else begin
      if (step) begin
        if (slot_last) begin
          st_q  <= CH_IDLE;
          idx_q <= '0;
        end else begin
          idx_q <= idx_q + 2'd1;
        end
      end
      if (tick) begin
        hold_l_q <= in_l;
        hold_r_q <= stereo ? in_r : '0;
        st_q     <= CH_FILL;
        idx_q    <= '0;
      end
    end
  end

  assign upper = slot_up;
  assign right = slot_rt;
  assign rdata = pick_byte(slot_rt ? hold_r_q : hold_l_q, slot_up);
endmodule

// File: rtl/dseq_sticky.sv
module dseq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_q;
  always_ff @(posedge clk) begin
    if (!rst_n)   q_q <= 1'b0;
    else if (set) q_q <= 1'b1;
    else if (clr) q_q <= 1'b0;
  end
  assign q = q_q;
endmodule

// File: rtl/dma_byte_seq.sv
module dma_byte_seq
  import dseq_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_tick,
  input  logic              underrun_clr,
  input  logic              play_en,
  input  logic              play_pio,
  input  logic [1:0]        play_fmt,
  input  logic              play_stereo,
  input  logic              play_dak,
  input  logic              play_pio_wr,
  input  logic [BYTE_W-1:0] play_wdata,
  output logic              play_drq,
  output logic              play_upper,
  output logic              play_right,
  output logic [WORD_W-1:0] play_l,
  output logic [WORD_W-1:0] play_r,
  input  logic              cap_en,
  input  logic              cap_pio,
  input  logic [1:0]        cap_fmt,
  input  logic              cap_stereo,
  input  logic              cap_dak,
  input  logic              cap_pio_rd,
  input  logic [WORD_W-1:0] cap_l,
  input  logic [WORD_W-1:0] cap_r,
  output logic              cap_drq,
  output logic              cap_upper,
  output logic              cap_right,
  output logic [BYTE_W-1:0] cap_rdata,
  output logic              drq_any,
  output logic              underrun
);
  logic play_last_evt;
  logic play_ur_evt;
  logic cap_last_evt;

  dseq_play_chan #(.BYTE_W(BYTE_W)) u_play (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (fs_tick),
    .en       (play_en),
    .pio      (play_pio),
    .fmt      (play_fmt),
    .stereo   (play_stereo),
    .dak      (play_dak),
    .pio_stb  (play_pio_wr),
    .wdata    (play_wdata),
    .drq      (play_drq),
    .upper    (play_upper),
    .right    (play_right),
    .out_l    (play_l),
    .out_r    (play_r),
    .last_evt (play_last_evt),
    .ur_evt   (play_ur_evt)
  );

  dseq_cap_chan #(.BYTE_W(BYTE_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (fs_tick),
    .en       (cap_en),
    .pio      (cap_pio),
    .fmt      (cap_fmt),
    .stereo   (cap_stereo),
    .dak      (cap_dak),
    .pio_stb  (cap_pio_rd),
    .in_l     (cap_l),
    .in_r     (cap_r),
    .drq      (cap_drq),
    .upper    (cap_upper),
    .right    (cap_right),
    .rdata    (cap_rdata),
    .last_evt (cap_last_evt)
  );

  dseq_sticky u_ur (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (play_ur_evt),
    .clr   (underrun_clr),
    .q     (underrun)
  );

  assign drq_any = play_drq | cap_drq;
endmodule

// File: rtl/dseq_chk.sv
module dseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fs_tick,
  input logic       underrun_clr,
  input logic       play_pio,
  input logic [1:0] play_fmt,
  input logic       play_drq,
  input logic       play_upper,
  input logic       play_last_evt,
  input logic       play_ur_evt,
  input logic       cap_pio,
  input logic       cap_stereo,
  input logic       cap_drq,
  input logic       cap_right,
  input logic       cap_last_evt,
  input logic       underrun
);
  // R2
  play_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(play_drq) |-> $past(fs_tick));
  // R2
  cap_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_drq) |-> $past(fs_tick));
  // R2
  play_drop_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_last_evt |=> !play_drq);
  // R2
  cap_drop_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_last_evt && !fs_tick) |=> !cap_drq);
  // R7
  play_pio_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_pio |-> !play_drq);
  // R7
  cap_pio_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pio |-> !cap_drq);
  // R6
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_ur_evt |=> underrun);
  // R6
  underrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !underrun_clr) |=> underrun);
  // R5
  cap_mono_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_stereo |-> !cap_right);
  // R3
  play_narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (play_fmt == 2'b00 || play_fmt == 2'b11) |-> play_upper);
endmodule

bind dma_byte_seq dseq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fs_tick       (fs_tick),
  .underrun_clr  (underrun_clr),
  .play_pio      (play_pio),
  .play_fmt      (play_fmt),
  .play_drq      (play_drq),
  .play_upper    (play_upper),
  .play_last_evt (play_last_evt),
  .play_ur_evt   (play_ur_evt),
  .cap_pio       (cap_pio),
  .cap_stereo    (cap_stereo),
  .cap_drq       (cap_drq),
  .cap_right     (cap_right),
  .cap_last_evt  (cap_last_evt),
  .underrun      (underrun)
);

// File: tb/dma_byte_seq_tb.sv
module dma_byte_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs_tick = 0, underrun_clr = 0;
  logic play_en = 0, play_pio = 0, play_stereo = 0, play_dak = 0, play_pio_wr = 0;
  logic [1:0] play_fmt = 0;
  logic [7:0] play_wdata = 0;
  logic play_drq, play_upper, play_right;
  logic [15:0] play_l, play_r;
  logic cap_en = 0, cap_pio = 0, cap_stereo = 0, cap_dak = 0, cap_pio_rd = 0;
  logic [1:0] cap_fmt = 0;
  logic [15:0] cap_l = 0, cap_r = 0;
  logic cap_drq, cap_upper, cap_right;
  logic [7:0] cap_rdata;
  logic drq_any, underrun;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_byte_seq u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic pulse_tick();
    fs_tick = 1; cyc(); fs_tick = 0;
  endtask

  function automatic bit is_wide(int f);
    return (f == 1) || (f == 2);
  endfunction
  function automatic int exp_len(int f, bit s);
    int n = is_wide(f) ? 2 : 1;
    return s ? 2 * n : n;
  endfunction
  function automatic bit exp_right(int f, bit s, int k);
    return s && (k >= exp_len(f, s) / 2);
  endfunction
  function automatic bit exp_upper(int f, int k);
    if (!is_wide(f)) return 1'b1;
    return (f == 1) ? (k % 2 == 1) : (k % 2 == 0);
  endfunction
  function automatic logic [15:0] exp_word(int f, bit s, bit rt,
      logic [7:0] b0, logic [7:0] b1, logic [7:0] b2, logic [7:0] b3);
    logic [7:0] first, second;
    if (!is_wide(f)) return {(s && rt) ? b1 : b0, 8'h00};
    first  = (s && rt) ? b2 : b0;
    second = (s && rt) ? b3 : b1;
    return (f == 1) ? {second, first} : {first, second};
  endfunction

  task automatic send_play(input logic [7:0] b, input bit use_pio);
    play_wdata = b;
    if (use_pio) play_pio_wr = 1; else play_dak = 1;
    cyc();
    play_pio_wr = 0; play_dak = 0;
  endtask

  task automatic play_run(input int f, input bit s, input logic [7:0] base, input bit use_pio);
    logic [7:0] b [4];
    int n = exp_len(f, s);
    for (int k = 0; k < 4; k++) b[k] = base + 8'h11 * k[7:0];
    play_fmt = f[1:0]; play_stereo = s; play_pio = use_pio; play_en = 1;
    cyc();
    pulse_tick();
    chk($sformatf("R2 play req after tick f%0d s%0d", f, s), play_drq, !use_pio);
    for (int k = 0; k < n; k++) begin
      chk($sformatf("R3 play upper f%0d s%0d k%0d", f, s, k), play_upper, exp_upper(f, k));
      chk($sformatf("R3 play right f%0d s%0d k%0d", f, s, k), play_right, exp_right(f, s, k));
      send_play(b[k], use_pio);
      if (k < n - 1) chk($sformatf("R2 play req held f%0d s%0d k%0d", f, s, k), play_drq, !use_pio);
    end
    chk($sformatf("R2 play req drop f%0d s%0d", f, s), play_drq, 0);
    play_wdata = 8'hFF; play_dak = 1; cyc(); play_dak = 0;
    chk("R8 play stray ack no req", play_drq, 0);
    pulse_tick();
    chk($sformatf("R4 play_l f%0d s%0d", f, s), play_l, exp_word(f, s, 0, b[0], b[1], b[2], b[3]));
    chk($sformatf("R4 play_r f%0d s%0d", f, s), play_r, exp_word(f, s, 1, b[0], b[1], b[2], b[3]));
    chk("R2 play req new frame", play_drq, !use_pio);
    play_en = 0; cyc();
    chk("R10 play req off when disabled", play_drq, 0);
    play_pio = 0;
  endtask

  task automatic cap_run(input int f, input bit s, input logic [15:0] lw, input logic [15:0] rw, input bit use_pio);
    int n = exp_len(f, s);
    logic [15:0] w;
    logic [7:0] eb;
    cap_fmt = f[1:0]; cap_stereo = s; cap_pio = use_pio; cap_l = lw; cap_r = rw; cap_en = 1;
    cyc();
    pulse_tick();
    cap_l = ~lw; cap_r = ~rw;
    chk($sformatf("R2 cap req after tick f%0d s%0d", f, s), cap_drq, !use_pio);
    for (int k = 0; k < n; k++) begin
      chk($sformatf("R3 cap upper f%0d s%0d k%0d", f, s, k), cap_upper, exp_upper(f, k));
      chk($sformatf("R5 cap right f%0d s%0d k%0d", f, s, k), cap_right, exp_right(f, s, k));
      w  = exp_right(f, s, k) ? rw : lw;
      eb = exp_upper(f, k) ? w[15:8] : w[7:0];
      chk($sformatf("R5 cap byte f%0d s%0d k%0d", f, s, k), cap_rdata, eb);
      if (use_pio) cap_pio_rd = 1; else cap_dak = 1;
      cyc();
      cap_pio_rd = 0; cap_dak = 0;
    end
    chk($sformatf("R2 cap req drop f%0d s%0d", f, s), cap_drq, 0);
    cap_en = 0; cyc();
    cap_pio = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      nfail++;
      $display("FAIL R2 watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] keep_l, keep_r;
    repeat (3) cyc();
    chk("R1 play req in reset", play_drq, 0);
    chk("R1 cap req in reset", cap_drq, 0);
    rst_n = 1; cyc();
    chk("R1 drq_any after reset", drq_any, 0);
    chk("R1 underrun after reset", underrun, 0);
    chk("R1 play_l after reset", play_l, 0);
    chk("R1 play_r after reset", play_r, 0);

    for (int f = 0; f < 4; f++)
      for (int s = 0; s < 2; s++)
        play_run(f, s[0], 8'h10 + 8'h20 * f[7:0] + 8'h08 * s[7:0], 1'b0);

    // R7 playback through the data register
    play_run(2, 1'b1, 8'h3C, 1'b1);
    play_run(0, 1'b1, 8'h5A, 1'b1);

    // R6 underrun: 16-bit LE stereo, only half the frame before the strobe
    keep_l = play_l; keep_r = play_r;
    play_fmt = 2'b01; play_stereo = 1; play_en = 1; cyc();
    pulse_tick();
    send_play(8'hA1, 0); send_play(8'hA2, 0);
    pulse_tick();
    chk("R6 underrun set", underrun, 1);
    chk("R6 play_l kept", play_l, keep_l);
    chk("R6 play_r kept", play_r, keep_r);
    chk("R6 req still up", play_drq, 1);
    chk("R3 position kept after underrun", play_right, 1);
    send_play(8'hA3, 0); send_play(8'hA4, 0);
    repeat (3) cyc();
    chk("R6 underrun sticky", underrun, 1);
    pulse_tick();
    chk("R4 play_l after late frame", play_l, 16'hA2A1);
    chk("R4 play_r after late frame", play_r, 16'hA4A3);
    fs_tick = 1; underrun_clr = 1; cyc(); fs_tick = 0; underrun_clr = 0;
    chk("R6 set wins over clear", underrun, 1);
    underrun_clr = 1; cyc(); underrun_clr = 0;
    chk("R6 underrun cleared", underrun, 0);

    // R10 disable mid-frame restarts at first slot
    play_en = 0; cyc();
    play_en = 1; cyc();
    pulse_tick();
    send_play(8'h01, 0);
    chk("R10 mid-frame slot", play_upper, 1);
    play_en = 0; cyc(); play_en = 1; cyc();
    chk("R10 no req before tick", play_drq, 0);
    pulse_tick();
    chk("R10 restart upper", play_upper, 0);
    chk("R10 restart right", play_right, 0);
    play_en = 0; cyc();
    underrun_clr = 1; cyc(); underrun_clr = 0;

    for (int f = 0; f < 4; f++)
      for (int s = 0; s < 2; s++)
        cap_run(f, s[0], 16'h1234 + 16'h1111 * f[15:0], 16'hA5C3 - 16'h0101 * f[15:0], 1'b0);
    cap_run(1, 1'b1, 16'hBEEF, 16'hCAFE, 1'b1);
    cap_run(2, 1'b0, 16'h7E81, 16'h0000, 1'b1);

    // R9 full duplex
    play_fmt = 0; play_stereo = 0; play_en = 1;
    cap_fmt = 0; cap_stereo = 0; cap_l = 16'h9900; cap_en = 1; cyc();
    pulse_tick();
    chk("R9 both req play", play_drq, 1);
    chk("R9 both req cap", cap_drq, 1);
    chk("R9 drq_any both", drq_any, 1);
    send_play(8'h77, 0);
    chk("R9 play done", play_drq, 0);
    chk("R9 cap still up", cap_drq, 1);
    chk("R9 drq_any cap only", drq_any, 1);
    chk("R9 cap byte", cap_rdata, 8'h99);
    cap_dak = 1; cyc(); cap_dak = 0;
    chk("R9 drq_any none", drq_any, 0);
    pulse_tick();
    chk("R9 play word duplex", play_l, 16'h7700);
    chk("R9 underrun idle", underrun, 0);
    play_en = 0; cap_en = 0; cyc();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule